// File: doc/BRIEF.md
# Codec Reset and Output Mute Sequencer

This block turns three reset sources into one internal reset and two mute controls for an audio converter pair. The sources are an asynchronous power-on request and two active-low power-down pins, one for the input (ADC) path and one for the output (DAC) path. Any of these sources starts the sequence. While a request is present, the core is held in reset, the DAC output is tied to ground level, and ADC data words are forced to zero.

When every request has gone, the internal reset stays asserted for a fixed run of master clock cycles. After the reset falls, two blanking windows open. Both windows are counted in sample periods, using a one-cycle sample tick. In the first window the DAC output is held at midscale. In the second, longer window the ADC data stays zeroed. A new request at any point sends the sequence back to its start. The power-down pins are synchronised to the master clock. A low pulse on a pin counts as a request only if it lasts long enough.

The controller is a four-state machine:

- `ST_HOLD`: a request is present.
- `ST_EXTEND`: reset extension.
- `ST_BLANK`: one or both windows are still open.
- `ST_RUN`: normal operation.

The transitions are:

- T_RELEASE: `ST_HOLD` to `ST_EXTEND`, taken at the first edge with no request.
- T_EXT_DONE: `ST_EXTEND` to `ST_BLANK`, taken after `RST_EXT_CYC` cycles.
- T_WIN_DONE: `ST_BLANK` to `ST_RUN`, taken once both windows have expired.
- T_RESTART: from any state to `ST_HOLD`, taken when a request appears.

Top module: `codec_rst_seq`

## Requirements
- R1: While `por_req` is 1, the outputs are `core_rst`=1, `dac_out_sel`=2'b00 and `adc_zero`=1. These values appear at once, without waiting for a clock edge.
- R2: A power-down pin that is low for `PD_MIN_CYC` consecutive clock edges raises `core_rst` within `PD_MIN_CYC`+3 cycles. Before use, each pin passes through a two-stage synchroniser whose stages reset to 1.
- R3: A low pulse on a power-down pin that is seen at fewer than `PD_MIN_CYC` clock edges is ignored. `core_rst` and `dac_out_sel` stay unchanged.
- R4: Take the first clock edge at which no request is present. From that edge, `core_rst` stays 1 for exactly `RST_EXT_CYC` further cycles.
- R5: Whenever `core_rst` is 1, `dac_out_sel` is 2'b00 (ground level).
- R6: After `core_rst` falls, `dac_out_sel` is 2'b01 (midscale) until `DAC_HOLD_SMP` sample ticks have been seen. From the cycle after the last of those ticks, it is 2'b10 (live data).
- R7: After `core_rst` falls, `adc_zero` stays 1 until `ADC_HOLD_SMP` sample ticks have been seen. It then drops to 0, and is 1 again only when a new request arrives.
- R8: A qualified request during the extension, the blanking or normal running restarts the whole sequence. `core_rst` returns to 1, `dac_out_sel` returns to 2'b00, and the window counts restart from zero.
- R9: Sample ticks that arrive while `core_rst` is 1 do not shorten either blanking window.
- R10: `dac_out_sel` never takes the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| smp_tick | input | 1 | One-cycle pulse, once per sample period |
| por_req | input | 1 | Power-on reset request, active high, asynchronous |
| adc_pd_n | input | 1 | Input-path power-down pin, active low, asynchronous |
| dac_pd_n | input | 1 | Output-path power-down pin, active low, asynchronous |
| core_rst | output | 1 | Internal reset, active high |
| dac_out_sel | output | 2 | DAC drive select: 00 ground, 01 midscale, 10 live |
| adc_zero | output | 1 | 1 forces ADC data words to zero |

## Verification
The boundary most likely to break is a fresh power-down request that qualifies in the same cycle as the reset extension completes. In that cycle, T_RESTART and T_EXT_DONE compete, and T_RESTART must win. The bench provokes this by releasing one power-down pin and then lowering the other after a delay. The delay is swept one cycle at a time across the end of the extension, so the request lands before, on and after the last extension cycle. A behavioural reference model judges each cycle by comparing all three outputs, and tick counts taken at each window end confirm that blanking restarted in full.

// File: rtl/codec_rst_pkg.sv
`timescale 1ns/1ps
package codec_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_EXTEND = 2'd1,
        ST_BLANK  = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    localparam logic [1:0] DAC_SEL_GND  = 2'b00;
    localparam logic [1:0] DAC_SEL_MID  = 2'b01;
    localparam logic [1:0] DAC_SEL_LIVE = 2'b10;

    localparam int NUM_PD_PINS = 2;

endpackage

// File: rtl/codec_pd_qual.sv
`timescale 1ns/1ps
// Synchronises one active-low power-down pin and qualifies its low level
// against a minimum width in master clock cycles.
module codec_pd_qual #(
    parameter int MIN_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic req
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_CYC);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] low_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
        end
    end

    // saturating count of consecutive low samples
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            low_q <= '0;
        end else if (sync_q) begin
            low_q <= '0;
        end else if (low_q != FULL) begin
            low_q <= low_q + 1'b1;
        end
    end

    assign req = (low_q == FULL);

endmodule

// File: rtl/codec_win_cnt.sv
`timescale 1ns/1ps
// Saturating window counter: cleared while clr is high, advances on step,
// flags done once LIMIT steps have been taken.
module codec_win_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIM);

endmodule

// File: rtl/codec_rst_seq.sv
`timescale 1ns/1ps
module codec_rst_seq
    import codec_rst_pkg::*;
#(
    parameter int RST_EXT_CYC  = 1024,
    parameter int DAC_HOLD_SMP = 16384,
    parameter int ADC_HOLD_SMP = 18432,
    parameter int PD_MIN_CYC   = 8
) (
    input  logic       mclk,
    input  logic       smp_tick,
    input  logic       por_req,
    input  logic       adc_pd_n,
    input  logic       dac_pd_n,
    output logic       core_rst,
    output logic [1:0] dac_out_sel,
    output logic       adc_zero
);
    // extension counter counts cycles 0..LIMIT inside ST_EXTEND
    localparam int EXT_LAST = RST_EXT_CYC - 1;

    seq_state_e             state_q, state_d;
    logic [NUM_PD_PINS-1:0] pd_pins_n;
    logic [NUM_PD_PINS-1:0] pd_req;
    logic                   pd_any;
    logic                   ext_done, dac_done, adc_done;

    assign pd_pins_n = {dac_pd_n, adc_pd_n};

    for (genvar g = 0; g < NUM_PD_PINS; g++) begin : g_pd
        codec_pd_qual #(.MIN_CYC(PD_MIN_CYC)) u_qual (
            .clk   (mclk),
            .rst   (por_req),
            .pin_n (pd_pins_n[g]),
            .req   (pd_req[g])
        );
    end

    assign pd_any = |pd_req;

    codec_win_cnt #(.LIMIT(EXT_LAST)) u_ext_cnt (
        .clk  (mclk),
        .rst  (por_req),
        .clr  (state_q != ST_EXTEND),
        .step (1'b1),
        .done (ext_done)
    );

    codec_win_cnt #(.LIMIT(DAC_HOLD_SMP)) u_dac_cnt (
        .clk  (mclk),
        .rst  (por_req),
        .clr  (state_q != ST_BLANK),
        .step (smp_tick),
        .done (dac_done)
    );

    codec_win_cnt #(.LIMIT(ADC_HOLD_SMP)) u_adc_cnt (
        .clk  (mclk),
        .rst  (por_req),
        .clr  (state_q != ST_BLANK),
        .step (smp_tick),
        .done (adc_done)
    );

    always_ff @(posedge mclk or posedge por_req) begin
        if (por_req) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!pd_any) state_d = ST_EXTEND;            // T_RELEASE
            end
            ST_EXTEND: begin
                if (pd_any)        state_d = ST_HOLD;        // T_RESTART
                else if (ext_done) state_d = ST_BLANK;       // T_EXT_DONE
            end
            ST_BLANK: begin
                if (pd_any)                     state_d = ST_HOLD;  // T_RESTART
                else if (dac_done && adc_done)  state_d = ST_RUN;   // T_WIN_DONE
            end
            ST_RUN: begin
                if (pd_any) state_d = ST_HOLD;               // T_RESTART
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        core_rst    = 1'b1;
        dac_out_sel = DAC_SEL_GND;
        adc_zero    = 1'b1;
        unique case (state_q)
            ST_HOLD, ST_EXTEND: begin
                core_rst    = 1'b1;
                dac_out_sel = DAC_SEL_GND;
                adc_zero    = 1'b1;
            end
            ST_BLANK: begin
                core_rst    = 1'b0;
                dac_out_sel = dac_done ? DAC_SEL_LIVE : DAC_SEL_MID;
                adc_zero    = !adc_done;
            end
            ST_RUN: begin
                core_rst    = 1'b0;
                dac_out_sel = DAC_SEL_LIVE;
                adc_zero    = 1'b0;
            end
            default: begin
                core_rst    = 1'b1;
                dac_out_sel = DAC_SEL_GND;
                adc_zero    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/codec_rst_seq_chk.sv
`timescale 1ns/1ps
module codec_rst_seq_chk (
    input logic       mclk,
    input logic       por_req,
    input logic       core_rst,
    input logic [1:0] dac_out_sel,
    input logic       adc_zero
);
    // R1
    por_hold_chk: assert property (@(posedge mclk)
        por_req |-> (core_rst && dac_out_sel == 2'b00 && adc_zero));

    // R5
    rst_gnd_chk: assert property (@(posedge mclk) disable iff (por_req)
        core_rst |-> (dac_out_sel == 2'b00));

    // R10
    sel_code_chk: assert property (@(posedge mclk) disable iff (por_req)
        dac_out_sel != 2'b11);

    // R6
    first_blank_chk: assert property (@(posedge mclk) disable iff (por_req)
        $fell(core_rst) |-> (dac_out_sel == 2'b01 && adc_zero));

    // R8
    live_exit_chk: assert property (@(posedge mclk) disable iff (por_req)
        ($past(dac_out_sel) == 2'b10 && dac_out_sel != 2'b10) |-> core_rst);

    // R7
    adc_live_chk: assert property (@(posedge mclk) disable iff (por_req)
        !adc_zero |-> !core_rst);

endmodule

bind codec_rst_seq codec_rst_seq_chk u_chk (
    .mclk        (mclk),
    .por_req     (por_req),
    .core_rst    (core_rst),
    .dac_out_sel (dac_out_sel),
    .adc_zero    (adc_zero)
);

// File: tb/codec_rst_seq_bench.sv
`timescale 1ns/1ps
module codec_rst_seq_bench;
    localparam int P_RST = 16;
    localparam int P_DAC = 20;
    localparam int P_ADC = 24;
    localparam int P_PD  = 4;

    logic       mclk = 1'b0;
    logic       smp_tick = 1'b0;
    logic       por_req = 1'b0;
    logic       adc_pd_n = 1'b1;
    logic       dac_pd_n = 1'b1;
    logic       core_rst;
    logic [1:0] dac_out_sel;
    logic       adc_zero;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit tick_en = 1;
    int tick_phase = 0;

    always #2.5 mclk = ~mclk;

    codec_rst_seq #(
        .RST_EXT_CYC (P_RST),
        .DAC_HOLD_SMP(P_DAC),
        .ADC_HOLD_SMP(P_ADC),
        .PD_MIN_CYC  (P_PD)
    ) u_codec_rst_seq (
        .mclk       (mclk),
        .smp_tick   (smp_tick),
        .por_req    (por_req),
        .adc_pd_n   (adc_pd_n),
        .dac_pd_n   (dac_pd_n),
        .core_rst   (core_rst),
        .dac_out_sel(dac_out_sel),
        .adc_zero   (adc_zero)
    );

    // sample tick: one cycle in three, driven just after each rising edge
    always @(posedge mclk) begin
        #1;
        tick_phase = (tick_phase + 1) % 3;
        smp_tick = tick_en && (tick_phase == 0);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_s1a = 1, m_s2a = 1, m_s1d = 1, m_s2d = 1;
    int m_lowa = 0, m_lowd = 0;
    int m_ph = 0;        // 0 held, 1 extending, 2 blanking, 3 running
    int m_ext = 0, m_dac = 0, m_adc = 0;

    always @(posedge mclk or posedge por_req) begin
        if (por_req) begin
            m_s1a = 1; m_s2a = 1; m_s1d = 1; m_s2d = 1;
            m_lowa = 0; m_lowd = 0;
            m_ph = 0; m_ext = 0; m_dac = 0; m_adc = 0;
        end else begin
            bit req;
            req = (m_lowa >= P_PD) || (m_lowd >= P_PD);
            case (m_ph)
                0: if (!req) begin m_ph = 1; m_ext = 0; end
                1: begin
                    if (req) m_ph = 0;
                    else if (m_ext == P_RST - 1) begin m_ph = 2; m_dac = 0; m_adc = 0; end
                    else m_ext++;
                end
                2: begin
                    if (req) m_ph = 0;
                    else if (m_dac >= P_DAC && m_adc >= P_ADC) m_ph = 3;
                    else if (smp_tick) begin
                        if (m_dac < P_DAC) m_dac++;
                        if (m_adc < P_ADC) m_adc++;
                    end
                end
                default: if (req) m_ph = 0;
            endcase
            m_lowa = m_s2a ? 0 : ((m_lowa < P_PD) ? m_lowa + 1 : m_lowa);
            m_lowd = m_s2d ? 0 : ((m_lowd < P_PD) ? m_lowd + 1 : m_lowd);
            m_s2a = m_s1a; m_s1a = adc_pd_n;
            m_s2d = m_s1d; m_s1d = dac_pd_n;
        end
    end

    function automatic int exp_rst();  return (m_ph < 2) ? 1 : 0; endfunction
    function automatic int exp_dac();
        if (m_ph < 2) return 0;
        if (m_ph == 2 && m_dac < P_DAC) return 1;
        return 2;
    endfunction
    function automatic int exp_adc();
        return (m_ph < 2 || (m_ph == 2 && m_adc < P_ADC)) ? 1 : 0;
    endfunction

    // ---------------- per-cycle monitor ----------------
    bit bad_code = 0;
    bit rst_seen = 0;
    bit prev_rst = 1, prev_adc = 1;
    int prev_dac = 0;
    int dac_ticks = 0, adc_ticks = 0, rst_ticks = 0;

    always @(negedge mclk) begin
        if (!finished) begin
            chk(core_rst == exp_rst(), "R4 core_rst vs model", int'(core_rst), exp_rst());
            chk(int'(dac_out_sel) == exp_dac(), "R6 dac_out_sel vs model", int'(dac_out_sel), exp_dac());
            chk(adc_zero == exp_adc(), "R7 adc_zero vs model", int'(adc_zero), exp_adc());
            if (dac_out_sel == 2'b11) bad_code = 1;
            if (core_rst) begin
                rst_seen = 1;
                if (!prev_rst) rst_ticks = 0;
                dac_ticks = 0;
                adc_ticks = 0;
                if (smp_tick) rst_ticks++;
            end else begin
                if (dac_out_sel == 2'b01 && smp_tick) dac_ticks++;
                if (adc_zero && smp_tick) adc_ticks++;
                if (prev_dac == 1 && dac_out_sel == 2'b10) begin
                    chk(dac_ticks == P_DAC, "R6 midscale window ticks", dac_ticks, P_DAC);
                    chk(rst_ticks > 0 && dac_ticks == P_DAC, "R9 ticks in reset not counted",
                        dac_ticks, P_DAC);
                end
                if (prev_adc && !adc_zero)
                    chk(adc_ticks == P_ADC, "R7 zero-data window ticks", adc_ticks, P_ADC);
            end
            prev_rst = core_rst;
            prev_dac = int'(dac_out_sel);
            prev_adc = adc_zero;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge mclk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wait_mid();
        for (int i = 0; i < 200; i++) begin
            @(negedge mclk);
            if (dac_out_sel == 2'b01) break;
        end
    endtask

    initial begin
        repeat (60000) @(posedge mclk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cnt;
        #1 por_req = 1'b1;
        cyc(4);
        @(negedge mclk);
        chk(core_rst == 1'b1, "R1 core_rst during por", int'(core_rst), 1);
        chk(dac_out_sel == 2'b00, "R1 dac ground during por", int'(dac_out_sel), 0);
        chk(adc_zero == 1'b1, "R1 adc zero during por", int'(adc_zero), 1);

        // R4: extension length after release
        cyc(1);
        por_req = 1'b0;
        @(posedge mclk);
        cnt = 0;
        @(negedge mclk);
        while (core_rst && cnt < 1000) begin
            cnt++;
            @(negedge mclk);
        end
        chk(cnt == P_RST, "R4 extension length", cnt, P_RST);
        cyc(120);
        chk(!core_rst && dac_out_sel == 2'b10 && !adc_zero, "R7 running state",
            int'(dac_out_sel), 2);

        // R3: pulse one edge short of qualifying
        rst_seen = 0;
        adc_pd_n = 1'b0;
        cyc(P_PD - 1);
        adc_pd_n = 1'b1;
        cyc(20);
        chk(!rst_seen, "R3 short pulse ignored", int'(rst_seen), 0);
        chk(dac_out_sel == 2'b10, "R3 dac stays live", int'(dac_out_sel), 2);

        // R2/R5: pulse of exactly the minimum width
        dac_pd_n = 1'b0;
        cyc(P_PD);
        dac_pd_n = 1'b1;
        cyc(4);
        @(negedge mclk);
        chk(core_rst == 1'b1, "R2 minimum pulse resets", int'(core_rst), 1);
        chk(dac_out_sel == 2'b00, "R5 dac ground in reset", int'(dac_out_sel), 0);

        // R8: restart from inside the blanking window, ticks paused briefly
        wait_mid();
        tick_en = 0;
        cyc(10);
        tick_en = 1;
        adc_pd_n = 1'b0;
        cyc(P_PD + 3);
        @(negedge mclk);
        chk(core_rst == 1'b1, "R8 restart from blanking", int'(core_rst), 1);
        adc_pd_n = 1'b1;
        cyc(3);
        @(negedge mclk);
        chk(dac_out_sel == 2'b00, "R8 dac back to ground", int'(dac_out_sel), 0);
        cyc(130);
        chk(!adc_zero && dac_out_sel == 2'b10, "R8 sequence completes again",
            int'(adc_zero), 0);

        // R8: restart from running
        dac_pd_n = 1'b0;
        cyc(P_PD + 3);
        @(negedge mclk);
        chk(core_rst == 1'b1, "R8 restart from running", int'(core_rst), 1);
        dac_pd_n = 1'b1;
        cyc(130);

        // same-cycle sweep: new request against the end of the extension
        for (int d = 8; d <= 22; d++) begin
            dac_pd_n = 1'b0;
            cyc(P_PD + 2);
            dac_pd_n = 1'b1;
            cyc(d);
            adc_pd_n = 1'b0;
            cyc(P_PD + 2);
            adc_pd_n = 1'b1;
            cyc(130);
            chk(!core_rst && !adc_zero, "R8 sweep recovers", int'(adc_zero), 0);
        end

        chk(!bad_code, "R10 no 2'b11 code", int'(bad_code), 0);
        finish_run();
    end

endmodule